// File: doc/BRIEF.md
# Encoded Core-Clock Post-Divider

This block sits after a clock multiplier and derives the core clock from its fast output. A packed mode word configures it. Three fields are decoded. An enable bit and a two-bit source selector choose between the multiplied path and a slow bypass clock. A four-bit ratio code then chooses either the fast clock undivided or a division by an even ratio from 2 to 30. The fast input is expected to run at roughly 100 to 350 MHz, and the even ratios let the core run below that range.

A new word is captured on a load strobe and held as pending. It takes over only when the current output period has finished. For a divided output, that point is the end of the low phase, so no short pulse ever reaches the core. A status flag drops when a word is loaded and rises in the cycle the new setting becomes active. A synchronous reset in the fast clock domain puts the block into undivided bypass until the first load.

Top module: `clk_postdiv`

## Requirements
- R1: While reset is held, and after it until the first load takes effect, `clk_out` follows `byp_clk` and `cfg_active` is low.
- R2: The multiplied path is used only when mode bit 24 is 1 and mode bits 1:0 equal 2'b11. Any other combination routes `byp_clk` to `clk_out` undivided. All other mode bits are ignored.
- R3: On the multiplied path, ratio code 4'b1111 (mode bits 7:4) makes `clk_out` equal to `fast_clk`.
- R4: On the multiplied path, ratio code n from 0 to 14 gives a period of 2*(n+1) `fast_clk` cycles: high for n+1 cycles, then low for n+1 cycles.
- R5: When the current output is divided, a pending setting takes effect only on the edge that ends a complete low phase. If the new setting is divided, its first cycle is high.
- R6: `cfg_active` is low from the edge that captures a load until the edge on which that setting takes effect. It is high from that edge onward.
- R7: A load that arrives while an earlier load is still pending replaces it, and only the later setting is applied.
- R8: When the current output is undivided (bypass or ratio 1), a loaded setting takes effect on the first `fast_clk` edge after the edge that captured it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Multiplied high-rate clock; also clocks all state |
| byp_clk | input | 1 | Bypass clock routed out when the multiplied path is not chosen |
| rst | input | 1 | Synchronous active-high reset, fast_clk domain |
| cfg_word | input | 32 | Packed mode word |
| cfg_load | input | 1 | One-cycle strobe that captures `cfg_word` |
| clk_out | output | 1 | Derived core clock |
| cfg_active | output | 1 | High once the last loaded setting is in effect |

## Verification
The bench builds the block with its default parameters: a 32-bit mode word, a four-bit ratio code, the enable at bit 24 and the selector at bits 1:0. With these defaults every one of the sixteen ratio codes is exercised, including the longest half period of 15 cycles. Because the ratio code is only four bits wide, the bench can wait out the slowest possible boundary well within its time limit. The bench measures the length of the old low phase at the moment of each switch, which tests the boundary rule across every pair of old and new ratios that the random sequence produces.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Width of the ratio code; the half-period counter shares it.
  localparam int FIELD_W = 4;
  localparam int HALF_W  = FIELD_W;
  localparam logic [FIELD_W-1:0] CODE_UNDIV = {FIELD_W{1'b1}};

  typedef enum logic [1:0] {
    SRC_BYPASS = 2'd0,
    SRC_FAST   = 2'd1,
    SRC_DIV    = 2'd2
  } src_e;

  typedef struct packed {
    src_e              src;
    logic [HALF_W-1:0] half;  // fast cycles per output phase when divided
  } clkcfg_t;

  localparam clkcfg_t CFG_RESET = '{src: SRC_BYPASS, half: HALF_W'(1)};

  // Ratio code -> half period. The all-ones code means "no division".
  function automatic logic [HALF_W-1:0] code_to_half(input logic [FIELD_W-1:0] code);
    return (code == CODE_UNDIV) ? HALF_W'(1) : HALF_W'(code + 1'b1);
  endfunction

  function automatic clkcfg_t decode_cfg(input logic pll_on,
                                         input logic [1:0] sel,
                                         input logic [FIELD_W-1:0] code);
    clkcfg_t c;
    c.half = code_to_half(code);
    if (!(pll_on && sel == 2'b11)) c.src = SRC_BYPASS;
    else if (code == CODE_UNDIV)   c.src = SRC_FAST;
    else                           c.src = SRC_DIV;
    return c;
  endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter int MODE_W    = 32,
  parameter int EN_BIT    = 24,
  parameter int SEL_LSB   = 0,
  parameter int FIELD_LSB = 4
) (
  input  logic [MODE_W-1:0] mode_word,
  output clkcfg_t           cfg
);

  logic               pll_on;
  logic [1:0]         sel;
  logic [FIELD_W-1:0] code;

  assign pll_on = mode_word[EN_BIT];
  assign sel    = mode_word[SEL_LSB +: 2];
  assign code   = mode_word[FIELD_LSB +: FIELD_W];
  assign cfg    = decode_cfg(pll_on, sel, code);

  // The half period must never be zero, or the counter would never wrap.
  always_comb begin
    assert_half_nonzero_R4: assert (cfg.half != '0);
  end

endmodule

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow
  import clkdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  clkcfg_t cfg_in,
  input  logic    boundary,   // current output period has just completed
  output clkcfg_t cur_cfg,
  output clkcfg_t pend_cfg,
  output logic    apply_evt,
  output logic    active
);

  logic pend_valid;

  assign apply_evt = pend_valid && boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_cfg    <= CFG_RESET;
      pend_cfg   <= CFG_RESET;
      pend_valid <= 1'b0;
      active     <= 1'b0;
    end else begin
      if (apply_evt) cur_cfg <= pend_cfg;
      if (load) begin
        // A later load overwrites whatever is still waiting (R7).
        pend_cfg   <= cfg_in;
        pend_valid <= 1'b1;
        active     <= 1'b0;
      end else if (apply_evt) begin
        pend_valid <= 1'b0;
        active     <= 1'b1;
      end
    end
  end

  assert_reset_bypass_R1: assert property (@(posedge clk)
    $past(rst) |-> (cur_cfg.src == SRC_BYPASS && !active));

  assert_load_drops_active_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> !active);

  assert_active_from_pending_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(pend_valid));

endmodule

// File: rtl/clkdiv_toggle.sv
module clkdiv_toggle
  import clkdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  clkcfg_t cur_cfg,
  input  clkcfg_t nxt_cfg,
  input  logic    apply_evt,
  output logic    div_q,
  output logic    boundary
);

  logic [HALF_W-1:0] cnt;
  logic              phase_end;
  logic              is_div;

  assign is_div    = (cur_cfg.src == SRC_DIV);
  assign phase_end = (cnt == cur_cfg.half - HALF_W'(1));
  // Undivided outputs have no phase to protect; divided ones switch after low.
  assign boundary  = is_div ? (phase_end && !div_q) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (apply_evt) begin
      cnt   <= '0;
      div_q <= (nxt_cfg.src == SRC_DIV);
    end else if (is_div) begin
      if (phase_end) begin
        cnt   <= '0;
        div_q <= ~div_q;
      end else begin
        cnt <= cnt + HALF_W'(1);
      end
    end else begin
      cnt   <= '0;
      div_q <= 1'b0;
    end
  end

  assert_cnt_below_half_R4: assert property (@(posedge clk) disable iff (rst)
    is_div |-> (cnt < cur_cfg.half));

  assert_idle_when_undivided_R3: assert property (@(posedge clk) disable iff (rst)
    !is_div |-> (!div_q && cnt == '0));

  assert_first_phase_high_R5: assert property (@(posedge clk) disable iff (rst)
    (apply_evt && nxt_cfg.src == SRC_DIV) |=> (div_q && cnt == '0));

  assert_toggle_after_full_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (is_div && !apply_evt && cnt != cur_cfg.half - HALF_W'(1)) |=> $stable(div_q));

endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
  import clkdiv_pkg::*;
#(
  parameter int MODE_W    = 32,
  parameter int EN_BIT    = 24,
  parameter int SEL_LSB   = 0,
  parameter int FIELD_LSB = 4
) (
  input  logic              fast_clk,
  input  logic              byp_clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] cfg_word,
  input  logic              cfg_load,
  output logic              clk_out,
  output logic              cfg_active
);

  clkcfg_t dec_cfg;
  clkcfg_t cur_cfg;
  clkcfg_t pend_cfg;
  logic    apply_evt;
  logic    boundary;
  logic    div_q;

  clkdiv_decode #(
    .MODE_W(MODE_W), .EN_BIT(EN_BIT), .SEL_LSB(SEL_LSB), .FIELD_LSB(FIELD_LSB)
  ) u_decode (
    .mode_word(cfg_word),
    .cfg      (dec_cfg)
  );

  clkdiv_shadow u_shadow (
    .clk      (fast_clk),
    .rst      (rst),
    .load     (cfg_load),
    .cfg_in   (dec_cfg),
    .boundary (boundary),
    .cur_cfg  (cur_cfg),
    .pend_cfg (pend_cfg),
    .apply_evt(apply_evt),
    .active   (cfg_active)
  );

  clkdiv_toggle u_toggle (
    .clk      (fast_clk),
    .rst      (rst),
    .cur_cfg  (cur_cfg),
    .nxt_cfg  (pend_cfg),
    .apply_evt(apply_evt),
    .div_q    (div_q),
    .boundary (boundary)
  );

  always_comb begin
    unique case (cur_cfg.src)
      SRC_FAST: clk_out = fast_clk;
      SRC_DIV:  clk_out = div_q;
      default:  clk_out = byp_clk;
    endcase
  end

  // Apply from a divided source only after its output has gone low (R5).
  assert_switch_after_low_R5: assert property (@(posedge fast_clk) disable iff (rst)
    (apply_evt && cur_cfg.src == SRC_DIV) |-> !clk_out);

endmodule

// File: tb/clk_postdiv_bench.sv
module clk_postdiv_bench;

  logic        fast_clk = 1'b0;
  logic        byp_clk  = 1'b0;
  logic        rst      = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        cfg_load = 1'b0;
  logic        clk_out;
  logic        cfg_active;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_s = 0, cur_run = 0, prev_s = 0, prev_run = 0;
  int old_kind = 0;  // 0 bypass, 1 undivided fast, 2 divided
  int old_half = 1;

  always #10 fast_clk = ~fast_clk;
  always #17 byp_clk  = ~byp_clk;

  clk_postdiv u_clk_postdiv (
    .fast_clk  (fast_clk),
    .byp_clk   (byp_clk),
    .rst       (rst),
    .cfg_word  (cfg_word),
    .cfg_load  (cfg_load),
    .clk_out   (clk_out),
    .cfg_active(cfg_active)
  );

  // Bench restatement of the mode word rules.
  function automatic int kind_of(input logic [31:0] w);
    if (w[24] !== 1'b1 || w[1:0] !== 2'b11) return 0;
    return (w[7:4] == 4'd15) ? 1 : 2;
  endfunction

  function automatic int half_of(input logic [31:0] w);
    int ratio;
    ratio = (w[7:4] == 4'd15) ? 1 : 2 * (int'(w[7:4]) + 1);
    return (ratio == 1) ? 1 : ratio / 2;
  endfunction

  function automatic logic [31:0] mk(input bit en, input logic [1:0] sel, input logic [3:0] code);
    logic [31:0] junk;
    junk = $urandom & ~32'h0100_00F3;
    return junk | (32'(en) << 24) | (32'(code) << 4) | 32'(sel);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge fast_clk);
    #1;
    prev_s   = cur_s;
    prev_run = cur_run;
    if (int'(clk_out) == cur_s) cur_run++;
    else begin
      cur_s   = int'(clk_out);
      cur_run = 1;
    end
  endtask

  task automatic verify_pattern(input int kind, input int half);
    if (kind == 2) begin
      check(cur_s == 1, "R5", "first divided cycle level", cur_s, 1);
      for (int j = 1; j < 4 * half; j++) begin
        int e;
        step();
        e = ((j / half) % 2 == 0) ? 1 : 0;
        check(int'(clk_out) == e, "R4", "divided waveform", int'(clk_out), e);
      end
    end else if (kind == 1) begin
      repeat (5) begin
        check(clk_out === 1'b1, "R3", "ratio-1 high phase", int'(clk_out), 1);
        @(negedge fast_clk); #1;
        check(clk_out === 1'b0, "R3", "ratio-1 low phase", int'(clk_out), 0);
        step();
      end
    end else begin
      repeat (5) begin
        check(clk_out === byp_clk, "R2", "bypass follows", int'(clk_out), int'(byp_clk));
        #6;
        check(clk_out === byp_clk, "R2", "bypass follows late", int'(clk_out), int'(byp_clk));
        step();
      end
    end
  endtask

  task automatic load_word(input logic [31:0] w);
    cfg_word = w;
    cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  task automatic load_and_verify(input logic [31:0] w);
    int kind, half, waited;
    kind = kind_of(w);
    half = half_of(w);
    load_word(w);
    check(cfg_active == 1'b0, "R6", "flag after load", int'(cfg_active), 0);
    waited = 0;
    while (!cfg_active && waited < 80) begin
      step();
      waited++;
    end
    check(cfg_active == 1'b1, "R6", "flag raised", int'(cfg_active), 1);
    if (old_kind != 2)
      check(waited == 1, "R8", "cycles to apply from undivided", waited, 1);
    else
      check(prev_s == 0 && prev_run == old_half, "R5", "old low phase length",
            (prev_s == 0) ? prev_run : -1, old_half);
    verify_pattern(kind, half);
    old_kind = kind;
    old_half = half;
  endtask

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: state under reset and just after it
    repeat (3) begin
      step();
      check(cfg_active == 1'b0, "R1", "flag under reset", int'(cfg_active), 0);
      check(clk_out === byp_clk, "R1", "bypass under reset", int'(clk_out), int'(byp_clk));
    end
    rst = 1'b0;
    repeat (4) begin
      step();
      check(cfg_active == 1'b0, "R1", "flag before load", int'(cfg_active), 0);
      check(clk_out === byp_clk, "R1", "bypass before load", int'(clk_out), int'(byp_clk));
    end

    // Directed corners: every ratio extreme and the R2 gating rules.
    load_and_verify(mk(1'b1, 2'b11, 4'd0));
    load_and_verify(mk(1'b1, 2'b11, 4'd14));
    load_and_verify(mk(1'b1, 2'b11, 4'd15));
    load_and_verify(mk(1'b0, 2'b11, 4'd3));   // R2: enable clear
    load_and_verify(mk(1'b1, 2'b10, 4'd3));   // R2: selector not 11
    load_and_verify(mk(1'b1, 2'b11, 4'd6));
    load_and_verify(mk(1'b1, 2'b11, 4'd1));

    // R7: overwrite a pending load during a long divided period.
    load_and_verify(mk(1'b1, 2'b11, 4'd14));
    load_word(mk(1'b1, 2'b11, 4'd0));
    step();
    check(cfg_active == 1'b0, "R7", "flag while first pending", int'(cfg_active), 0);
    load_and_verify(mk(1'b1, 2'b11, 4'd3));

    // Random sweep over codes and selectors.
    for (int i = 0; i < 40; i++) begin
      logic [3:0] code;
      logic [1:0] sel;
      bit en;
      code = 4'($urandom_range(0, 15));
      sel  = ($urandom_range(0, 3) != 0) ? 2'b11 : 2'($urandom_range(0, 2));
      en   = ($urandom_range(0, 4) != 0);
      load_and_verify(mk(en, sel, code));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule